// File: doc/BRIEF.md
# Upward-Growing Byte Stack with Word Sequencing

This block holds an 8-bit stack pointer and the small internal RAM that the stack occupies. A core issues single-byte pushes and pops, or two-byte pushes and pops for subroutine entry, return and interrupt entry, through one request port. Each request moves the pointer by one byte per step. A push advances the pointer before it writes, and a pop reads before it retreats, so the pointer always names the topmost occupied byte.

Word pushes store the low byte of the 16-bit return address first and the high byte second. Word pops take the high byte first. Either kind of word operation takes two clocks. Other logic can also load the pointer directly when no stack operation is running. Reset places the pointer at 07h, so the first byte pushed goes to address 08h, and reset clears every RAM byte.

Top module: `upstack_ctl`

## Requirements
- R1: After reset, sp is 07h, busy and done are 0, rd_data is 0000h, and every RAM byte reads back as 00h.
- R2: A request accepted with req_op=00 (push byte) sets sp to sp+1 and writes req_wdata[7:0] to the new sp address. The first push after reset goes to 08h.
- R3: A request accepted with req_op=01 (pop byte) reads the byte at the current sp into rd_data[7:0], clears rd_data[15:8], and then sets sp to sp-1.
- R4: A byte push or pop finishes on its accepting edge. done is 1 for exactly the following cycle and busy stays 0.
- R5: A request with req_op=10 (push word) writes req_wdata[7:0] at sp+1 on the first edge and req_wdata[15:8] at sp+2 on the second. busy is 1 between the two edges, and done is 1 for the one cycle after the second edge.
- R6: A request with req_op=11 (pop word) reads the high byte at sp, then the low byte at sp-1, and leaves sp lowered by 2. When done is 1, rd_data holds {high, low}.
- R7: A request is accepted only when busy is 0. A request presented while busy is 1 has no effect on sp, the RAM or rd_data.
- R8: When busy is 0 and no request is present, sp_we loads sp_wdata into sp at the next edge. sp_we is ignored while busy is 1 and ignored on the cycle a request is accepted.
- R9: sp wraps modulo 256 in both directions: a push at FFh goes to 00h and a pop at 00h goes to FFh.
- R10: With RAM_BYTES=128, a push to an address at or above 80h stores nothing, and a pop from such an address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Stack request present |
| req_op | input | 2 | 00 push byte, 01 pop byte, 10 push word, 11 pop word |
| req_wdata | input | 16 | Push data; low byte used for byte push |
| sp_we | input | 1 | Direct pointer load |
| sp_wdata | input | 8 | Value for direct pointer load |
| rd_data | output | 16 | Popped data |
| busy | output | 1 | Second step of a word operation pending |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 8 | Current stack pointer |

## Verification
The bench pushes two distinct bytes and pops them back. Wrong ordering between the pointer update and the RAM access shows up either as swapped data or as a read of the cleared byte at 07h. Word pushes are read back both as two byte pops and as one word pop, which separates errors in byte order from errors in the word sequencer. A competing request and a pointer load are injected during the busy cycle to prove they are ignored. Runs across FFh/00h and 7Fh/80h expose wrap and out-of-range handling.

// File: rtl/upstack_ctl.sv
module upstack_ctl #(
  parameter int RAM_BYTES = 128,
  parameter logic [7:0] SP_RESET = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [15:0] req_wdata,
  input  logic        sp_we,
  input  logic [7:0]  sp_wdata,
  output logic [15:0] rd_data,
  output logic        busy,
  output logic        done,
  output logic [7:0]  sp
);
  localparam int AW = $clog2(RAM_BYTES);
  localparam logic [8:0] LIMIT = 9'(RAM_BYTES);

  logic [7:0] mem [RAM_BYTES];
  logic       second, second_pop;
  logic [7:0] hold_hi;

  logic       accept, step, is_pop, wr_ok, rd_ok;
  logic [7:0] sp_up, wr_byte, rd_byte;

  assign accept  = req_valid && !second;
  assign step    = accept || second;
  assign is_pop  = second ? second_pop : req_op[0];
  assign sp_up   = sp + 8'd1;
  assign wr_byte = second ? hold_hi : req_wdata[7:0];
  assign wr_ok   = {1'b0, sp_up} < LIMIT;
  assign rd_ok   = {1'b0, sp} < LIMIT;
  assign rd_byte = rd_ok ? mem[sp[AW-1:0]] : 8'h00;
  assign busy    = second;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp         <= SP_RESET;
      second     <= 1'b0;
      second_pop <= 1'b0;
      hold_hi    <= 8'h00;
      rd_data    <= 16'h0000;
      done       <= 1'b0;
      for (int i = 0; i < RAM_BYTES; i++) mem[i] <= 8'h00;
    end else begin
      done <= 1'b0;
      if (step) begin
        if (is_pop) begin
          sp <= sp - 8'd1;
          if (second)         rd_data[7:0]  <= rd_byte;
          else if (req_op[1]) rd_data[15:8] <= rd_byte;
          else                rd_data       <= {8'h00, rd_byte};
        end else begin
          sp <= sp_up;
          if (wr_ok) mem[sp_up[AW-1:0]] <= wr_byte;
        end
        if (second) begin
          second <= 1'b0;
          done   <= 1'b1;
        end else if (req_op[1]) begin
          second     <= 1'b1;
          second_pop <= req_op[0];
          hold_hi    <= req_wdata[15:8];
        end else begin
          done <= 1'b1;
        end
      end else if (sp_we) begin
        sp <= sp_wdata;
      end
    end
  end

  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_op == 2'b00 |=> sp == $past(sp) + 8'd1);
  // R3
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_op == 2'b01 |=> sp == $past(sp) - 8'd1);
  // R4
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && !req_op[1] |=> done && !busy);
  // R5
  word_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done && !busy);
  // R8
  sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !req_valid && sp_we |=> sp == $past(sp_wdata));
endmodule

// File: tb/test_upstack_ctl.sv
module test_upstack_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [15:0] req_wdata = 16'h0000;
  logic        sp_we = 1'b0;
  logic [7:0]  sp_wdata = 8'h00;
  logic [15:0] rd_data;
  logic        busy, done;
  logic [7:0]  sp;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  upstack_ctl i_upstack_ctl (.clk, .rst_n, .req_valid, .req_op, .req_wdata,
    .sp_we, .sp_wdata, .rd_data, .busy, .done, .sp);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_sp(input logic [7:0] v);
    @(negedge clk); sp_we = 1'b1; sp_wdata = v;
    @(posedge clk); @(negedge clk); sp_we = 1'b0;
  endtask

  task automatic byte_op(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk); req_valid = 1'b1; req_op = op; req_wdata = {8'h00, d};
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 sp", {8'h00, sp}, 16'h0007);
    chk("R1 busy", {15'h0, busy}, 16'h0000);
    chk("R1 done", {15'h0, done}, 16'h0000);
    chk("R1 rd_data", rd_data, 16'h0000);
  endtask

  task automatic t_bytes;
    byte_op(2'b00, 8'hAA);
    chk("R2 sp after push", {8'h00, sp}, 16'h0008);
    chk("R4 done after push", {14'h0, busy, done}, 16'h0001);
    byte_op(2'b00, 8'h55);
    chk("R2 sp second push", {8'h00, sp}, 16'h0009);
    byte_op(2'b01, 8'h00);
    chk("R3 pop data", rd_data, 16'h0055);
    chk("R3 sp after pop", {8'h00, sp}, 16'h0008);
    byte_op(2'b01, 8'h00);
    chk("R2 first push at 08h", rd_data, 16'h00AA);
    chk("R4 done after pop", {14'h0, busy, done}, 16'h0001);
    @(negedge clk);
    chk("R4 done one cycle", {15'h0, done}, 16'h0000);
    byte_op(2'b01, 8'h00);
    chk("R1 ram cleared at 07h", rd_data, 16'h0000);
    chk("R3 sp to 06h", {8'h00, sp}, 16'h0006);
  endtask

  task automatic t_words;
    load_sp(8'h20);
    @(negedge clk); req_valid = 1'b1; req_op = 2'b10; req_wdata = 16'h1234;
    @(posedge clk); @(negedge clk);
    chk("R5 busy mid", {14'h0, busy, done}, 16'h0002);
    chk("R5 sp mid", {8'h00, sp}, 16'h0021);
    req_op = 2'b01; sp_we = 1'b1; sp_wdata = 8'h55;
    @(posedge clk); @(negedge clk); req_valid = 1'b0; sp_we = 1'b0;
    chk("R5 done end", {14'h0, busy, done}, 16'h0001);
    chk("R7 R8 sp ignores busy inputs", {8'h00, sp}, 16'h0022);
    chk("R7 rd_data untouched", rd_data, 16'h0000);
    byte_op(2'b01, 8'h00);
    chk("R5 high byte on top", rd_data, 16'h0012);
    byte_op(2'b01, 8'h00);
    chk("R5 low byte below", rd_data, 16'h0034);
    chk("R5 sp restored", {8'h00, sp}, 16'h0020);
    @(negedge clk); req_valid = 1'b1; req_op = 2'b10; req_wdata = 16'hABCD;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    @(negedge clk); req_valid = 1'b1; req_op = 2'b11;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    chk("R6 busy mid", {14'h0, busy, done}, 16'h0002);
    @(posedge clk); @(negedge clk);
    chk("R6 word data", rd_data, 16'hABCD);
    chk("R6 sp minus two", {8'h00, sp}, 16'h0020);
    chk("R6 done", {15'h0, done}, 16'h0001);
  endtask

  task automatic t_spwrite;
    load_sp(8'h40);
    chk("R8 idle load", {8'h00, sp}, 16'h0040);
    @(negedge clk); sp_we = 1'b1; sp_wdata = 8'h70;
    req_valid = 1'b1; req_op = 2'b00; req_wdata = 16'h0011;
    @(posedge clk); @(negedge clk); sp_we = 1'b0; req_valid = 1'b0;
    chk("R8 load loses to request", {8'h00, sp}, 16'h0041);
  endtask

  task automatic t_wrap_range;
    load_sp(8'hFF);
    byte_op(2'b00, 8'h77);
    chk("R9 push wraps to 00h", {8'h00, sp}, 16'h0000);
    byte_op(2'b01, 8'h00);
    chk("R9 pop data at 00h", rd_data, 16'h0077);
    chk("R9 pop wraps to FFh", {8'h00, sp}, 16'h00FF);
    byte_op(2'b01, 8'h00);
    chk("R10 read above 7Fh is zero", rd_data, 16'h0000);
    load_sp(8'h7F);
    byte_op(2'b00, 8'h99);
    chk("R10 sp reaches 80h", {8'h00, sp}, 16'h0080);
    byte_op(2'b01, 8'h00);
    chk("R10 write above 7Fh dropped", rd_data, 16'h0000);
    chk("R10 sp back to 7Fh", {8'h00, sp}, 16'h007F);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_bytes();
    t_words();
    t_spwrite();
    t_wrap_range();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule